// File: doc/BRIEF.md
# Translation Unit Control and Fault Register Block

This block is the register slave that sits beside an address translation datapath. Software writes a control code to switch translation on or off, or to ask the datapath to stop taking new requests. It also programs a configuration word and the physical base of the first-level page table, and it requests whole-cache or single-page invalidation of the translation cache. Each request is turned into a one-cycle pulse toward the datapath.

The datapath reports faults as strobes, each carrying a fault type and the address it was translating. The block keeps one pending bit per fault type. It stores each fault address in a capture register shared by faults of the same direction: read-side faults share one register and write-side faults share another, while page faults and bus errors each have a register of their own. While any fault is pending, the interrupt output is high and the datapath is held blocked. Software reads the pending bits, reads the captured address, and clears the bits it has handled by writing ones.

Blocking is a handshake. Once a block is requested, either by software or by a pending fault, the block waits for the datapath to report that it has drained. It then shows a blocked status bit, which software polls before it touches the tables.

Top module: `xlat_ctrl_regs`

## Requirements
- R1: After reset, the control, configuration, table base, status and interrupt status registers read 0. `irq`, `xlat_enable` and `block_req` are 0. The version register at 0x034 reads the constant `VERSION`, whose bits [31:28] are 3.
- R2: A write of exactly 0x5 to the control register (0x000) enables translation with no block request. A write of 0x7 keeps translation enabled and raises `block_req`. A write of 0x0 clears both. Any other value leaves the register unchanged. Reading 0x000 returns the current code.
- R3: Status bit 0 (0x008) becomes 1 in the cycle after `drain_done` is sampled high while `block_req` is high. It stays 1 while `block_req` stays high, even if `drain_done` falls. It returns to 0 in the cycle after `block_req` is sampled low.
- R4: A strobe on `flt_valid` with type t sets bit t of the interrupt status register (0x018) on the next edge. The bits are: 0 page fault, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security, 7 write protection. `irq` is the OR of all pending bits.
- R5: The fault address is captured according to the fault type. Type 0 goes to 0x024 and type 3 goes to 0x030. Types 1, 4 and 5 go to the read-side register 0x02C. Types 2, 6 and 7 go to the write-side register 0x028. With the default `HOLD_FIRST`=0, a later fault overwrites the captured address.
- R6: Writing to 0x01C clears every pending bit where the written data has a 1 and leaves the other bits as they were. A fault of type t that arrives in the same cycle as a clear of bit t leaves bit t set.
- R7: `block_req` is high whenever any fault is pending, whatever the control code.
- R8: Writing to 0x00C with bit 0 set gives a one-cycle `flush_all` pulse in the cycle after the write. With bit 0 clear, no pulse is given.
- R9: Writing to 0x010 with bit 0 set gives a one-cycle `flush_entry` pulse in the cycle after the write, with `flush_page` equal to data bits [31:12]. With bit 0 clear, no pulse is given.
- R10: The configuration (0x004) and table base (0x014) registers read back what was written and drive `cfg_word` and `table_base`.
- R11: Writes to the status, interrupt status and version registers have no effect. Offsets 0x00C, 0x010, 0x01C and any offset outside the map read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, available in the same cycle |
| drain_done | input | 1 | Datapath reports that no requests are in flight |
| flt_valid | input | 1 | Fault event strobe |
| flt_type | input | 3 | Fault type, which is the interrupt status bit index |
| flt_addr | input | 32 | Address that faulted |
| xlat_enable | output | 1 | Translation enabled |
| block_req | output | 1 | Request to stop accepting new translations |
| cfg_word | output | 32 | Configuration register contents |
| table_base | output | 32 | Page table base register contents |
| flush_all | output | 1 | One-cycle pulse: invalidate the whole translation cache |
| flush_entry | output | 1 | One-cycle pulse: invalidate one page |
| flush_page | output | 32-PAGE_SHIFT | Page number to invalidate |
| irq | output | 1 | Fault interrupt |

## Verification
The main function, fault latching and routing, is tried with a table that sends each of the eight fault types alone. Each one shows that the right pending bit sets and that the address lands in the register for its direction, and not in one of the three other capture registers. A second pattern raises two pending faults of different directions and clears only one of them, which tells a per-bit clear apart from a clear-all. A third pattern sends a fault in the same cycle as a clear of its own bit, which separates set-wins priority from clear-wins priority. The block handshake is tried with `drain_done` pulsed and then dropped, which separates a sticky blocked bit from one that just follows `drain_done`, and the flush writes are tried with bit 0 both set and clear.

// File: rtl/xlat_regs_pkg.sv
package xlat_regs_pkg;
   localparam int DW      = 32;
   localparam int NUM_FLT = 8;
   localparam int FLT_TW  = 3;
   localparam int NUM_SLOT = 4;

   localparam logic [7:0] OFF_CTRL  = 8'h00;
   localparam logic [7:0] OFF_CFG   = 8'h04;
   localparam logic [7:0] OFF_STAT  = 8'h08;
   localparam logic [7:0] OFF_FLALL = 8'h0C;
   localparam logic [7:0] OFF_FLENT = 8'h10;
   localparam logic [7:0] OFF_BASE  = 8'h14;
   localparam logic [7:0] OFF_IPEND = 8'h18;
   localparam logic [7:0] OFF_ICLR  = 8'h1C;
   localparam logic [7:0] OFF_A_PF  = 8'h24;
   localparam logic [7:0] OFF_A_WR  = 8'h28;
   localparam logic [7:0] OFF_A_RD  = 8'h2C;
   localparam logic [7:0] OFF_A_DS  = 8'h30;
   localparam logic [7:0] OFF_VER   = 8'h34;

   typedef enum logic [2:0] {
      MODE_OFF  = 3'd0,
      MODE_ON   = 3'd5,
      MODE_HOLD = 3'd7
   } mode_e;

   localparam logic [1:0] SLOT_PF = 2'd0;
   localparam logic [1:0] SLOT_WR = 2'd1;
   localparam logic [1:0] SLOT_RD = 2'd2;
   localparam logic [1:0] SLOT_DS = 2'd3;

   function automatic logic [1:0] route_slot(input logic [FLT_TW-1:0] t);
      case (t)
         3'd0:             return SLOT_PF;
         3'd3:             return SLOT_DS;
         3'd1, 3'd4, 3'd5: return SLOT_RD;
         default:          return SLOT_WR;
      endcase
   endfunction

   function automatic logic [NUM_FLT-1:0] slot_types(input logic [1:0] s);
      logic [NUM_FLT-1:0] m;
      for (int t = 0; t < NUM_FLT; t++)
         m[t] = (route_slot(FLT_TW'(t)) == s);
      return m;
   endfunction
endpackage

// File: rtl/xlat_mode_ctrl.sv
module xlat_mode_ctrl
   import xlat_regs_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctrl_we_i,
   input  logic [DW-1:0] ctrl_wdata_i,
   input  logic          drain_done_i,
   input  logic          fault_pend_i,
   output logic [2:0]    mode_o,
   output logic          enable_o,
   output logic          block_req_o,
   output logic          blocked_o
);
   mode_e mode_q;
   logic  blocked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_OFF;
      end else if (ctrl_we_i) begin
         case (ctrl_wdata_i)
            DW'(MODE_OFF):  mode_q <= MODE_OFF;
            DW'(MODE_ON):   mode_q <= MODE_ON;
            DW'(MODE_HOLD): mode_q <= MODE_HOLD;
            default:        mode_q <= mode_q;
         endcase
      end
   end

   assign block_req_o = (mode_q == MODE_HOLD) || fault_pend_i;
   assign enable_o    = (mode_q != MODE_OFF);
   assign mode_o      = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         blocked_q <= 1'b0;
      else if (!block_req_o)
         blocked_q <= 1'b0;
      else if (drain_done_i)
         blocked_q <= 1'b1;
   end

   assign blocked_o = blocked_q;

   // R3
   unblock_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !block_req_o |=> !blocked_o);
   // R3
   drain_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (block_req_o && drain_done_i) |=> blocked_o);
   // R2
   hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we_i && ctrl_wdata_i == DW'(MODE_HOLD)) |=> (block_req_o && enable_o));
endmodule

// File: rtl/xlat_fault_capture.sv
module xlat_fault_capture
   import xlat_regs_pkg::*;
#(
   parameter bit HOLD_FIRST = 1'b0
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flt_valid_i,
   input  logic [FLT_TW-1:0]          flt_type_i,
   input  logic [DW-1:0]              flt_addr_i,
   input  logic                       clr_we_i,
   input  logic [NUM_FLT-1:0]         clr_mask_i,
   output logic [NUM_FLT-1:0]         pend_o,
   output logic [NUM_SLOT-1:0][DW-1:0] slot_addr_o
);
   logic [NUM_FLT-1:0] pend_q;
   logic [NUM_FLT-1:0] set_vec;
   logic [NUM_FLT-1:0] clr_vec;
   logic [1:0]         hit_slot;

   assign set_vec  = flt_valid_i ? (NUM_FLT'(1) << flt_type_i) : '0;
   assign clr_vec  = clr_we_i ? clr_mask_i : '0;
   assign hit_slot = route_slot(flt_type_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= '0;
      else
         pend_q <= (pend_q & ~clr_vec) | set_vec;
   end

   assign pend_o = pend_q;

   for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
      logic          take;
      logic [DW-1:0] addr_q;
      if (HOLD_FIRST) begin : g_hold
         localparam logic [NUM_FLT-1:0] MASK = slot_types(2'(s));
         assign take = flt_valid_i && (hit_slot == 2'(s)) && ((pend_q & MASK) == '0);
      end else begin : g_last
         assign take = flt_valid_i && (hit_slot == 2'(s));
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            addr_q <= '0;
         else if (take)
            addr_q <= flt_addr_i;
      end
      assign slot_addr_o[s] = addr_q;
   end

   // R4
   event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid_i |=> pend_q[$past(flt_type_i)]);
   // R6
   clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we_i |=> ((pend_q & $past(clr_mask_i & ~set_vec)) == '0));
   // R6
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flt_valid_i |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/xlat_flush_gen.sv
module xlat_flush_gen #(
   parameter int PW = 20
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          all_we_i,
   input  logic          ent_we_i,
   input  logic          go_bit_i,
   input  logic [PW-1:0] page_i,
   output logic          flush_all_o,
   output logic          flush_entry_o,
   output logic [PW-1:0] flush_page_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_all_o   <= 1'b0;
         flush_entry_o <= 1'b0;
         flush_page_o  <= '0;
      end else begin
         flush_all_o   <= all_we_i && go_bit_i;
         flush_entry_o <= ent_we_i && go_bit_i;
         if (ent_we_i && go_bit_i)
            flush_page_o <= page_i;
      end
   end

   // R8
   flush_all_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all_o |-> $past(all_we_i && go_bit_i));
   // R9
   flush_ent_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_we_i && go_bit_i) |=> (flush_entry_o && flush_page_o == $past(page_i)));
endmodule

// File: rtl/xlat_ctrl_regs.sv
module xlat_ctrl_regs
   import xlat_regs_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter int          PAGE_SHIFT = 12,
   parameter logic [31:0] VERSION    = 32'h3000_0002,
   parameter bit          HOLD_FIRST = 1'b0,
   localparam int         PW         = DW - PAGE_SHIFT
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              drain_done,
   input  logic              flt_valid,
   input  logic [2:0]        flt_type,
   input  logic [31:0]       flt_addr,
   output logic              xlat_enable,
   output logic              block_req,
   output logic [31:0]       cfg_word,
   output logic [31:0]       table_base,
   output logic              flush_all,
   output logic              flush_entry,
   output logic [PW-1:0]     flush_page,
   output logic              irq
);
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must cover offsets up to 0x34");
   end
   if (PAGE_SHIFT < 1 || PAGE_SHIFT > DW - 1) begin : g_bad_page
      $error("PAGE_SHIFT out of range");
   end
   if (VERSION[31:28] != 4'h3) begin : g_bad_ver
      $error("VERSION major field must be 3");
   end

   function automatic logic at(input logic [7:0] off);
      return bus_addr == ADDR_W'(off);
   endfunction

   logic [2:0]                 mode;
   logic                       blocked;
   logic [NUM_FLT-1:0]         pend;
   logic [NUM_SLOT-1:0][DW-1:0] slot_addr;
   logic [DW-1:0]              cfg_q, base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         base_q <= '0;
      end else if (bus_wr) begin
         if (at(OFF_CFG))  cfg_q  <= bus_wdata;
         if (at(OFF_BASE)) base_q <= bus_wdata;
      end
   end

   assign cfg_word   = cfg_q;
   assign table_base = base_q;
   assign irq        = |pend;

   xlat_mode_ctrl u_mode (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctrl_we_i    (bus_wr && at(OFF_CTRL)),
      .ctrl_wdata_i (bus_wdata),
      .drain_done_i (drain_done),
      .fault_pend_i (irq),
      .mode_o       (mode),
      .enable_o     (xlat_enable),
      .block_req_o  (block_req),
      .blocked_o    (blocked)
   );

   xlat_fault_capture #(.HOLD_FIRST(HOLD_FIRST)) u_fault (
      .clk         (clk),
      .rst_n       (rst_n),
      .flt_valid_i (flt_valid),
      .flt_type_i  (flt_type),
      .flt_addr_i  (flt_addr),
      .clr_we_i    (bus_wr && at(OFF_ICLR)),
      .clr_mask_i  (bus_wdata[NUM_FLT-1:0]),
      .pend_o      (pend),
      .slot_addr_o (slot_addr)
   );

   xlat_flush_gen #(.PW(PW)) u_flush (
      .clk           (clk),
      .rst_n         (rst_n),
      .all_we_i      (bus_wr && at(OFF_FLALL)),
      .ent_we_i      (bus_wr && at(OFF_FLENT)),
      .go_bit_i      (bus_wdata[0]),
      .page_i        (bus_wdata[DW-1:PAGE_SHIFT]),
      .flush_all_o   (flush_all),
      .flush_entry_o (flush_entry),
      .flush_page_o  (flush_page)
   );

   always_comb begin
      bus_rdata = '0;
      if (at(OFF_CTRL))  bus_rdata = DW'(mode);
      if (at(OFF_CFG))   bus_rdata = cfg_q;
      if (at(OFF_STAT))  bus_rdata = DW'(blocked);
      if (at(OFF_BASE))  bus_rdata = base_q;
      if (at(OFF_IPEND)) bus_rdata = DW'(pend);
      if (at(OFF_A_PF))  bus_rdata = slot_addr[SLOT_PF];
      if (at(OFF_A_WR))  bus_rdata = slot_addr[SLOT_WR];
      if (at(OFF_A_RD))  bus_rdata = slot_addr[SLOT_RD];
      if (at(OFF_A_DS))  bus_rdata = slot_addr[SLOT_DS];
      if (at(OFF_VER))   bus_rdata = VERSION;
   end

   // R7
   pend_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> block_req);
   // R1
   version_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at(OFF_VER) |-> (bus_rdata == VERSION));
endmodule

// File: tb/xlat_ctrl_regs_test.sv
`timescale 1ns/1ps
module xlat_ctrl_regs_test;
   localparam logic [31:0] VER = 32'h3000_0002;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        drain_done = 1'b0;
   logic        flt_valid = 1'b0;
   logic [2:0]  flt_type = '0;
   logic [31:0] flt_addr = '0;
   logic        xlat_enable, block_req, flush_all, flush_entry, irq;
   logic [31:0] cfg_word, table_base;
   logic [19:0] flush_page;

   int checks = 0;
   int fails = 0;

   always #2 clk = ~clk;

   xlat_ctrl_regs #(.VERSION(VER)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .drain_done(drain_done),
      .flt_valid(flt_valid), .flt_type(flt_type), .flt_addr(flt_addr),
      .xlat_enable(xlat_enable), .block_req(block_req), .cfg_word(cfg_word),
      .table_base(table_base), .flush_all(flush_all), .flush_entry(flush_entry),
      .flush_page(flush_page), .irq(irq)
   );

   // {type, expected capture offset, fault address}
   localparam logic [42:0] VEC [0:7] = '{
      {3'd0, 8'h24, 32'h1000_0A00},
      {3'd1, 8'h2C, 32'h2100_0B04},
      {3'd2, 8'h28, 32'h3200_0C08},
      {3'd3, 8'h30, 32'h4300_0D0C},
      {3'd4, 8'h2C, 32'h5400_0E10},
      {3'd5, 8'h2C, 32'h6500_0F14},
      {3'd6, 8'h28, 32'h7600_1018},
      {3'd7, 8'h28, 32'h8700_111C}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic fault(input logic [2:0] t, input logic [31:0] a);
      @(negedge clk);
      flt_valid = 1'b1; flt_type = t; flt_addr = a;
      @(negedge clk);
      flt_valid = 1'b0;
   endtask

   initial begin
      #(4 * 100000);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [2:0]  t;
      logic [7:0]  off;
      logic [31:0] fa;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h00, v); chk("R1 ctrl", v, 0);
      rd(8'h04, v); chk("R1 cfg", v, 0);
      rd(8'h14, v); chk("R1 base", v, 0);
      rd(8'h08, v); chk("R1 status", v, 0);
      rd(8'h18, v); chk("R1 intstatus", v, 0);
      chk("R1 irq/enable/block", {29'd0, irq, xlat_enable, block_req}, 0);
      rd(8'h34, v); chk("R1 version", v, VER);
      chk("R1 version major", {28'd0, v[31:28]}, 3);

      // R2 control codes
      wr(8'h00, 32'h5);
      chk("R2 enable code", {30'd0, xlat_enable, block_req}, 32'b10);
      rd(8'h00, v); chk("R2 readback", v, 5);
      wr(8'h00, 32'h3);
      rd(8'h00, v); chk("R2 illegal code ignored", v, 5);
      wr(8'h00, 32'h7);
      chk("R2 block code", {30'd0, xlat_enable, block_req}, 32'b11);

      // R3 block handshake
      rd(8'h08, v); chk("R3 not blocked before drain", v, 0);
      @(negedge clk); drain_done = 1'b1;
      @(negedge clk); drain_done = 1'b0;
      rd(8'h08, v); chk("R3 blocked after drain", v, 1);
      @(negedge clk);
      rd(8'h08, v); chk("R3 blocked sticky", v, 1);
      wr(8'h00, 32'h5);
      @(negedge clk);
      rd(8'h08, v); chk("R3 unblocked", v, 0);

      // R10 configuration and base
      wr(8'h04, 32'h1234_5678);
      wr(8'h14, 32'hABCD_E000);
      chk("R10 cfg out", cfg_word, 32'h1234_5678);
      chk("R10 base out", table_base, 32'hABCD_E000);
      rd(8'h04, v); chk("R10 cfg rd", v, 32'h1234_5678);
      rd(8'h14, v); chk("R10 base rd", v, 32'hABCD_E000);

      // R11 read-only and zero offsets
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h08, v); chk("R11 status ro", v, 0);
      wr(8'h18, 32'hFF);
      rd(8'h18, v); chk("R11 intstatus ro", v, 0);
      wr(8'h34, 32'h0);
      rd(8'h34, v); chk("R11 version ro", v, VER);
      rd(8'h20, v); chk("R11 hole", v, 0);
      rd(8'h1C, v); chk("R11 clear reads 0", v, 0);
      rd(8'h0C, v); chk("R11 flush reads 0", v, 0);

      // R4 R5 R7 R6 vector walk
      for (int i = 0; i < 8; i++) begin
         t = VEC[i][42:40]; off = VEC[i][39:32]; fa = VEC[i][31:0];
         fault(t, fa);
         rd(8'h18, v); chk("R4 pending bit", v, 32'd1 << t);
         chk("R4 irq", {31'd0, irq}, 1);
         chk("R7 block while pending", {31'd0, block_req}, 1);
         rd(off, v); chk("R5 capture", v, fa);
         wr(8'h1C, 32'd1 << t);
         chk("R6 irq cleared", {31'd0, irq}, 0);
         chk("R7 block released", {31'd0, block_req}, 0);
      end
      rd(8'h24, v); chk("R5 page slot untouched", v, 32'h1000_0A00);
      rd(8'h30, v); chk("R5 bus slot untouched", v, 32'h4300_0D0C);
      rd(8'h2C, v); chk("R5 read slot latest", v, 32'h6500_0F14);

      // R6 partial clear
      fault(3'd1, 32'hAAAA_0000);
      fault(3'd6, 32'hBBBB_0000);
      rd(8'h18, v); chk("R6 two pending", v, 32'h42);
      wr(8'h1C, 32'h02);
      rd(8'h18, v); chk("R6 partial clear", v, 32'h40);
      // R6 set wins over clear in same cycle
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'h40;
      flt_valid = 1'b1; flt_type = 3'd6; flt_addr = 32'hCCCC_0000;
      @(negedge clk);
      bus_wr = 1'b0; flt_valid = 1'b0;
      rd(8'h18, v); chk("R6 set wins", v, 32'h40);
      rd(8'h28, v); chk("R5 write slot overwritten", v, 32'hCCCC_0000);
      wr(8'h1C, 32'hFF);
      rd(8'h18, v); chk("R6 clear all", v, 0);

      // R8 full flush
      wr(8'h0C, 32'h1);
      chk("R8 pulse", {31'd0, flush_all}, 1);
      @(negedge clk);
      chk("R8 pulse ends", {31'd0, flush_all}, 0);
      wr(8'h0C, 32'h0);
      chk("R8 bit0 clear no pulse", {31'd0, flush_all}, 0);

      // R9 entry flush
      wr(8'h10, 32'hDEAD_B001);
      chk("R9 pulse", {31'd0, flush_entry}, 1);
      chk("R9 page", {12'd0, flush_page}, 32'hDEADB);
      @(negedge clk);
      chk("R9 pulse ends", {31'd0, flush_entry}, 0);
      wr(8'h10, 32'h0000_5000);
      chk("R9 bit0 clear no pulse", {31'd0, flush_entry}, 0);

      // R2 disable
      wr(8'h00, 32'h0);
      chk("R2 disable", {30'd0, xlat_enable, block_req}, 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule